// File: doc/BRIEF.md
# Keyed-Unlock Countdown Watchdog with BCD Timeout

This block is a watchdog timer driven by a small register-write port (address, data, write strobe, read strobe). Software programs a timeout as an hours:minutes:seconds value and then arms the watchdog. While armed, a once-per-second tick input counts the time down. When the count runs out, the block emits a one-cycle expiry pulse, reloads the timeout and keeps counting. Software keeps the system alive by disarming and re-arming the watchdog, which restarts the countdown from the full timeout.

The arm bit is guarded against stray writes. A write to the control address only changes the arm bit when it comes directly after two key writes to that same address: first 0x55, then 0xAA. Any other write in between resets the key tracking. Hours are held in binary. Minutes and seconds are held in packed BCD. Out-of-range values are clamped when they are written. The counter itself steps down in BCD.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the arm bit is 0, the expiry output is 0, and the timeout registers read hours 0x00, minutes 0x01 and seconds 0x00, which is 60 s.
- R2: The arm bit (bit 0 of the control register at address 0) changes only on a control write whose two previous control writes were 0x55 and then 0xAA. That third write's bit 0 becomes the new arm bit.
- R3: A control write of the wrong value or in the wrong order, or a write to any other address, restarts the key sequence. Such a write leaves the arm bit unchanged.
- R4: Reading address 0 with the read strobe high returns the arm bit in bit 0 and zeros in the other bits. Addresses 1, 2 and 3 return hours, minutes and seconds.
- R5: Hours written above 1 are stored as 1. A minutes or seconds byte with a tens nibble above 5 or a units nibble above 9 is stored as 0x59. Legal values are stored unchanged.
- R6: Arming from the disarmed state loads the timeout T = 3600·h + 60·m + s. The expiry output is a single-cycle pulse that follows exactly the T-th tick counted while armed.
- R7: The count steps down in BCD. Seconds at 00 borrow from minutes and become 59, and minutes at 00 borrow from hours and become 59. The full 7199 s range therefore expires after exactly 7199 ticks.
- R8: After an expiry the counter reloads the armed timeout and keeps counting. The next pulse comes T ticks later.
- R9: Arming an already armed watchdog does not reload the count. Disarming an already disarmed one changes nothing.
- R10: Ticks are ignored while disarmed. Disarming and then re-arming restarts the countdown from the full timeout.
- R11: A programmed timeout of 0:00:00 is treated as 1 s.
- R12: Timeout registers written while armed do not alter the running countdown or its reload value until the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address (0 control, 1 hours, 2 minutes, 3 seconds) |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Combinational read data for the addressed register |
| sec_tick | input | 1 | One-cycle pulse once per second |
| expire_pulse | output | 1 | One-cycle pulse when the countdown runs out |

## Verification
The hardest case to reach is the hour-to-minute borrow deep in a long countdown. The bench reaches it by programming clamped illegal bytes to get 1:59:59. It also programs exactly 1:00:00, then issues a tick in every other cycle and checks the index of the tick on which the pulse appears. The key tracker's reset paths are reached by interleaving wrong values and foreign-address writes between key bytes. The arm bit is then read back after each of these interruptions.

// File: rtl/keyed_wdt_pkg.sv
// Package: shared types and BCD helpers for the keyed watchdog.
// Assumes BCD fields are one byte: tens nibble high, units nibble low.
package keyed_wdt_pkg;

    localparam int BCD_W = 8;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_stage_t;

    // Decrement one BCD byte; bit 8 of the result flags a borrow (00 -> 59).
    function automatic logic [BCD_W:0] bcd_step_down(input logic [BCD_W-1:0] v);
        logic [BCD_W:0] r;
        if (v[3:0] != 4'd0) begin
            r = {1'b0, v[7:4], v[3:0] - 4'd1};
        end else if (v[7:4] != 4'd0) begin
            r = {1'b0, v[7:4] - 4'd1, 4'd9};
        end else begin
            r = {1'b1, 8'h59};
        end
        return r;
    endfunction

    // Force an out-of-range BCD byte to the largest legal value 59.
    function automatic logic [BCD_W-1:0] bcd_clamp(input logic [BCD_W-1:0] v);
        logic [BCD_W-1:0] r;
        if ((v[7:4] > 4'd5) || (v[3:0] > 4'd9)) begin
            r = 8'h59;
        end else begin
            r = v;
        end
        return r;
    endfunction

endpackage

// File: rtl/wdt_key_gate.sv
// Module: wdt_key_gate
// Tracks the two-byte unlock key written to the control address and flags
// the control write that follows a complete key as a commit.
// Assumes wr_ctrl and wr_other are never high together.
module wdt_key_gate
    import keyed_wdt_pkg::*;
#(
    parameter int                 DATA_W = 8,
    parameter logic [DATA_W-1:0]  KEY_A  = 8'h55,
    parameter logic [DATA_W-1:0]  KEY_B  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_other,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output key_stage_t        stage
);

    // Advance the key tracker on control writes; any other write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= KEY_IDLE;
        end else if (wr_other) begin
            stage <= KEY_IDLE;
        end else if (wr_ctrl) begin
            unique case (stage)
                KEY_IDLE: stage <= (wdata == KEY_A) ? KEY_HALF : KEY_IDLE;
                KEY_HALF: stage <= (wdata == KEY_B) ? KEY_OPEN : KEY_IDLE;
                default:  stage <= KEY_IDLE;
            endcase
        end
    end

    // A control write is accepted only when the full key has been seen.
    always_comb begin
        commit = wr_ctrl && (stage == KEY_OPEN);
    end

endmodule

// File: rtl/wdt_time_regs.sv
// Module: wdt_time_regs
// Holds the programmed timeout: binary hours plus BCD minutes and seconds.
// Clamps illegal values at write time so stored fields are always legal.
// Assumes at most one of the write enables is high per cycle.
module wdt_time_regs
    import keyed_wdt_pkg::*;
#(
    parameter int                 HR_MAX  = 1,
    parameter logic [BCD_W-1:0]   DEF_HR  = 8'h00,
    parameter logic [BCD_W-1:0]   DEF_MIN = 8'h01,
    parameter logic [BCD_W-1:0]   DEF_SEC = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hr,
    input  logic             wr_min,
    input  logic             wr_sec,
    input  logic [BCD_W-1:0] wdata,
    output logic [BCD_W-1:0] hr_q,
    output logic [BCD_W-1:0] min_q,
    output logic [BCD_W-1:0] sec_q
);

    localparam int               N_BCD   = 2;
    localparam logic [BCD_W-1:0] HR_LIM  = BCD_W'(HR_MAX);

    logic [BCD_W-1:0] bcd_q   [N_BCD];
    logic             bcd_wr  [N_BCD];
    logic [BCD_W-1:0] bcd_def [N_BCD];

    // Route the two BCD field writes and reset values by index.
    always_comb begin
        bcd_wr[0]  = wr_min;
        bcd_wr[1]  = wr_sec;
        bcd_def[0] = DEF_MIN;
        bcd_def[1] = DEF_SEC;
    end

    // Store the binary hours field, saturating at the legal maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_q <= DEF_HR;
        end else if (wr_hr) begin
            hr_q <= (wdata > HR_LIM) ? HR_LIM : wdata;
        end
    end

    for (genvar g = 0; g < N_BCD; g++) begin : g_bcd_field
        // Store one BCD field, forcing illegal digits to 59.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bcd_q[g] <= bcd_def[g];
            end else if (bcd_wr[g]) begin
                bcd_q[g] <= bcd_clamp(wdata);
            end
        end
    end

    // Expose the BCD fields by name.
    always_comb begin
        min_q = bcd_q[0];
        sec_q = bcd_q[1];
    end

endmodule

// File: rtl/wdt_bcd_counter.sv
// Module: wdt_bcd_counter
// Counts an h:m:s value down in BCD, one step per tick while running.
// On arm it captures the timeout into a shadow copy and loads the count;
// on reaching the last second it pulses expire and reloads from the shadow.
// Assumes the arm values are legal (hours 0/1, BCD 00-59).
module wdt_bcd_counter
    import keyed_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic             tick,
    input  logic [BCD_W-1:0] arm_hr,
    input  logic [BCD_W-1:0] arm_min,
    input  logic [BCD_W-1:0] arm_sec,
    output logic             expire,
    output logic [BCD_W-1:0] cnt_hr,
    output logic [BCD_W-1:0] cnt_min,
    output logic [BCD_W-1:0] cnt_sec
);

    logic [BCD_W-1:0] sh_hr, sh_min, sh_sec;
    logic [BCD_W-1:0] ld_sec;
    logic             ld_zero;
    logic [BCD_W:0]   sec_step, min_step;
    logic [BCD_W-1:0] nx_hr, nx_min, nx_sec;
    logic             at_last;

    // A zero timeout is raised to one second so the count never starts at 0.
    always_comb begin
        ld_zero = (arm_hr == '0) && (arm_min == '0) && (arm_sec == '0);
        ld_sec  = ld_zero ? 8'h01 : arm_sec;
    end

    // Compute the next count value with seconds-to-minutes-to-hours borrow.
    always_comb begin
        sec_step = bcd_step_down(cnt_sec);
        min_step = bcd_step_down(cnt_min);
        nx_sec   = sec_step[BCD_W-1:0];
        nx_min   = sec_step[BCD_W] ? min_step[BCD_W-1:0] : cnt_min;
        nx_hr    = (sec_step[BCD_W] && min_step[BCD_W]) ? (cnt_hr - 8'd1) : cnt_hr;
        at_last  = (cnt_hr == '0) && (cnt_min == '0) && (cnt_sec == 8'h01);
    end

    // Capture the armed timeout so later register writes do not affect it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hr  <= '0;
            sh_min <= '0;
            sh_sec <= 8'h01;
        end else if (arm) begin
            sh_hr  <= arm_hr;
            sh_min <= arm_min;
            sh_sec <= ld_sec;
        end
    end

    // Load, step or reload the count and produce the expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hr  <= '0;
            cnt_min <= '0;
            cnt_sec <= 8'h01;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (arm) begin
                cnt_hr  <= arm_hr;
                cnt_min <= arm_min;
                cnt_sec <= ld_sec;
            end else if (run && tick) begin
                if (at_last) begin
                    expire  <= 1'b1;
                    cnt_hr  <= sh_hr;
                    cnt_min <= sh_min;
                    cnt_sec <= sh_sec;
                end else begin
                    cnt_hr  <= nx_hr;
                    cnt_min <= nx_min;
                    cnt_sec <= nx_sec;
                end
            end
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
// Module: keyed_wdt (top)
// Watchdog with a key-protected arm bit and an h:m:s BCD timeout.
// Register map: 0 control (bit 0 arm), 1 hours, 2 minutes, 3 seconds.
// Assumes sec_tick is a single-cycle pulse and one bus write per strobe cycle.
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int                ADDR_W   = 2,
    parameter int                DATA_W   = 8,
    parameter int                EN_BIT   = 0,
    parameter logic [DATA_W-1:0] KEY_A    = 8'h55,
    parameter logic [DATA_W-1:0] KEY_B    = 8'hAA,
    parameter int                HR_MAX   = 1,
    parameter logic [DATA_W-1:0] DEF_HR   = 8'h00,
    parameter logic [DATA_W-1:0] DEF_MIN  = 8'h01,
    parameter logic [DATA_W-1:0] DEF_SEC  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              expire_pulse
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(3);

    logic             wr_ctrl, wr_other;
    logic             commit;
    key_stage_t       key_stage;
    logic             en_q;
    logic             arm;
    logic [BCD_W-1:0] hr_q, min_q, sec_q;
    logic [BCD_W-1:0] cnt_hr, cnt_min, cnt_sec;

    // Split bus writes into control and non-control writes.
    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == A_CTRL);
        wr_other = bus_we && (bus_addr != A_CTRL);
    end

    wdt_key_gate #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) i_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_other (wr_other),
        .wdata    (bus_wdata),
        .commit   (commit),
        .stage    (key_stage)
    );

    // Hold the arm bit; it only follows a committed control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (commit) begin
            en_q <= bus_wdata[EN_BIT];
        end
    end

    // Reload only on a disarmed-to-armed change.
    always_comb begin
        arm = commit && bus_wdata[EN_BIT] && !en_q;
    end

    wdt_time_regs #(
        .HR_MAX  (HR_MAX),
        .DEF_HR  (DEF_HR[BCD_W-1:0]),
        .DEF_MIN (DEF_MIN[BCD_W-1:0]),
        .DEF_SEC (DEF_SEC[BCD_W-1:0])
    ) i_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hr  (bus_we && (bus_addr == A_HR)),
        .wr_min (bus_we && (bus_addr == A_MIN)),
        .wr_sec (bus_we && (bus_addr == A_SEC)),
        .wdata  (bus_wdata[BCD_W-1:0]),
        .hr_q   (hr_q),
        .min_q  (min_q),
        .sec_q  (sec_q)
    );

    wdt_bcd_counter i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .run     (en_q),
        .tick    (sec_tick),
        .arm_hr  (hr_q),
        .arm_min (min_q),
        .arm_sec (sec_q),
        .expire  (expire_pulse),
        .cnt_hr  (cnt_hr),
        .cnt_min (cnt_min),
        .cnt_sec (cnt_sec)
    );

    // Return the addressed register while the read strobe is high.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata[EN_BIT] = en_q;
                A_HR:    bus_rdata = DATA_W'(hr_q);
                A_MIN:   bus_rdata = DATA_W'(min_q);
                default: bus_rdata = DATA_W'(sec_q);
            endcase
        end
    end

endmodule

// File: rtl/keyed_wdt_checker.sv
// Module: keyed_wdt_checker
// Property checks for keyed_wdt, attached with bind below.
module keyed_wdt_checker
    import keyed_wdt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              sec_tick,
    input logic              expire_pulse,
    input logic              en_q,
    input key_stage_t        key_stage,
    input logic [BCD_W-1:0]  hr_q,
    input logic [BCD_W-1:0]  min_q,
    input logic [BCD_W-1:0]  sec_q,
    input logic [BCD_W-1:0]  cnt_hr,
    input logic [BCD_W-1:0]  cnt_min,
    input logic [BCD_W-1:0]  cnt_sec
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);

    // R2: the arm bit moves only on a control write after a full key
    p_arm_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> $past(bus_we && (bus_addr == A_CTRL) && (key_stage == KEY_OPEN)));

    // R3: a write elsewhere restarts the key tracker
    p_foreign_write_clears_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr != A_CTRL)) |=> (key_stage == KEY_IDLE));

    // R5: stored timeout fields are always legal
    p_fields_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_q <= 8'd1) && (min_q[7:4] <= 4'd5) && (min_q[3:0] <= 4'd9)
        && (sec_q[7:4] <= 4'd5) && (sec_q[3:0] <= 4'd9));

    // R6: an expiry pulse follows a tick seen while armed
    p_expire_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> $past(sec_tick && en_q));

    // R7: the running count stays legal BCD and never reaches zero
    p_count_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hr <= 8'd1) && (cnt_min[7:4] <= 4'd5) && (cnt_min[3:0] <= 4'd9)
        && (cnt_sec[7:4] <= 4'd5) && (cnt_sec[3:0] <= 4'd9)
        && ((cnt_hr | cnt_min | cnt_sec) != 8'd0));

    // R10: no expiry follows a cycle spent disarmed
    p_idle_no_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !expire_pulse);

endmodule

bind keyed_wdt keyed_wdt_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .sec_tick     (sec_tick),
    .expire_pulse (expire_pulse),
    .en_q         (en_q),
    .key_stage    (key_stage),
    .hr_q         (hr_q),
    .min_q        (min_q),
    .sec_q        (sec_q),
    .cnt_hr       (cnt_hr),
    .cnt_min      (cnt_min),
    .cnt_sec      (cnt_sec)
);

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       sec_tick = 1'b0;
    logic       expire_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    keyed_wdt i_keyed_wdt (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_rdata    (bus_rdata),
        .sec_tick     (sec_tick),
        .expire_pulse (expire_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = int'(bus_rdata);
        bus_re = 1'b0;
    endtask

    task automatic set_arm(input logic [7:0] v);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, v);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(2'd1, h); wr(2'd2, m); wr(2'd3, s);
    endtask

    // Issue n ticks; report the index of the first expiry and the pulse count.
    task automatic run_ticks(input int n, output int first, output int total);
        first = 0; total = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
            if (expire_pulse) begin
                total++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset;
        int v;
        check(expire_pulse == 1'b0, "R1 expire idle", int'(expire_pulse), 0);
        rd(2'd0, v); check(v == 0,     "R1 arm bit", v, 0);
        rd(2'd1, v); check(v == 0,     "R1 hours", v, 0);
        rd(2'd2, v); check(v == 'h01,  "R1 minutes", v, 'h01);
        rd(2'd3, v); check(v == 'h00,  "R1 seconds", v, 'h00);
    endtask

    task automatic t_key;
        int v;
        wr(2'd0, 8'h01);
        rd(2'd0, v); check(v == 0, "R3 unkeyed write ignored", v, 0);
        set_arm(8'hFF);
        rd(2'd0, v); check(v == 1, "R2 R4 keyed arm, other bits zero", v, 1);
        wr(2'd0, 8'h55); wr(2'd0, 8'h12); wr(2'd0, 8'hAA); wr(2'd0, 8'h00);
        rd(2'd0, v); check(v == 1, "R3 wrong value breaks key", v, 1);
        wr(2'd0, 8'hAA); wr(2'd0, 8'h55); wr(2'd0, 8'h00);
        rd(2'd0, v); check(v == 1, "R3 wrong order breaks key", v, 1);
        wr(2'd0, 8'h55); wr(2'd3, 8'h00); wr(2'd0, 8'hAA); wr(2'd0, 8'h00);
        rd(2'd0, v); check(v == 1, "R3 foreign address breaks key", v, 1);
        set_arm(8'h00);
        rd(2'd0, v); check(v == 0, "R2 keyed disarm", v, 0);
        set_arm(8'h00);
        rd(2'd0, v); check(v == 0, "R9 disarm when disarmed", v, 0);
    endtask

    task automatic t_clamp;
        int v;
        set_time(8'h07, 8'h6A, 8'h3C);
        rd(2'd1, v); check(v == 1,     "R5 hours clamp", v, 1);
        rd(2'd2, v); check(v == 'h59,  "R5 minutes clamp", v, 'h59);
        rd(2'd3, v); check(v == 'h59,  "R5 seconds clamp", v, 'h59);
        wr(2'd2, 8'h42);
        rd(2'd2, v); check(v == 'h42,  "R5 legal minutes kept", v, 'h42);
    endtask

    task automatic t_expiry;
        int f, t;
        set_time(8'h00, 8'h00, 8'h05);
        set_arm(8'h01);
        run_ticks(5, f, t);
        check(f == 5 && t == 1, "R6 expiry on tick 5", f, 5);
        @(negedge clk);
        check(expire_pulse == 1'b0, "R6 pulse one cycle", int'(expire_pulse), 0);
        run_ticks(5, f, t);
        check(f == 5 && t == 1, "R8 reload and second expiry", f, 5);
        set_arm(8'h00);
    endtask

    task automatic t_borrow;
        int f, t;
        set_time(8'h00, 8'h02, 8'h03);
        set_arm(8'h01);
        run_ticks(130, f, t);
        check(f == 123 && t == 1, "R7 minute borrow 2:03", f, 123);
        set_arm(8'h00);
        set_time(8'h01, 8'h00, 8'h00);
        set_arm(8'h01);
        run_ticks(3600, f, t);
        check(f == 3600 && t == 1, "R7 hour borrow 1:00:00", f, 3600);
        set_arm(8'h00);
        set_time(8'hFF, 8'hFF, 8'hFF);
        set_arm(8'h01);
        run_ticks(7199, f, t);
        check(f == 7199 && t == 1, "R7 R5 maximum 1:59:59", f, 7199);
        set_arm(8'h00);
    endtask

    task automatic t_idle_refresh;
        int f, t;
        set_time(8'h00, 8'h00, 8'h10);
        run_ticks(20, f, t);
        check(t == 0, "R10 ticks ignored while disarmed", t, 0);
        set_arm(8'h01);
        run_ticks(6, f, t);
        set_arm(8'h00);
        run_ticks(10, f, t);
        check(t == 0, "R10 no expiry after disarm", t, 0);
        set_arm(8'h01);
        run_ticks(10, f, t);
        check(f == 10 && t == 1, "R10 refresh restarts full timeout", f, 10);
        set_arm(8'h00);
    endtask

    task automatic t_rearm;
        int f, t;
        set_time(8'h00, 8'h00, 8'h10);
        set_arm(8'h01);
        run_ticks(6, f, t);
        set_arm(8'h01);
        run_ticks(4, f, t);
        check(f == 4 && t == 1, "R9 arm when armed keeps count", f, 4);
        set_arm(8'h00);
    endtask

    task automatic t_zero;
        int f, t;
        set_time(8'h00, 8'h00, 8'h00);
        set_arm(8'h01);
        run_ticks(3, f, t);
        check(f == 1 && t == 3, "R11 zero timeout acts as 1 s", t, 3);
        set_arm(8'h00);
    endtask

    task automatic t_shadow;
        int f, t;
        set_time(8'h00, 8'h00, 8'h05);
        set_arm(8'h01);
        run_ticks(2, f, t);
        wr(2'd3, 8'h02);
        run_ticks(3, f, t);
        check(f == 3 && t == 1, "R12 running count unaffected", f, 3);
        run_ticks(5, f, t);
        check(f == 5 && t == 1, "R12 reload keeps armed value", f, 5);
        set_arm(8'h00);
        set_arm(8'h01);
        run_ticks(2, f, t);
        check(f == 2 && t == 1, "R12 new value after re-arm", f, 2);
        set_arm(8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_key;
        t_clamp;
        t_expiry;
        t_borrow;
        t_idle_refresh;
        t_rearm;
        t_zero;
        t_shadow;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule